// File: doc/BRIEF.md
# Serial GPIO Shift Master

This block extends a group of parallel I/O lines over four wires by running a continuous serial frame against an external chain of shift registers. The block drives a divided serial clock, a load strobe that opens each frame, and a serial data output. It also samples a serial data input. Within each frame, the value for each line is taken from a parallel output word and shifted out least significant bit first. Over the same frame, one input bit per line is shifted back in.

A single 32-bit control word programs the block. Bit 0 enables it. Bits 9:6 give the frame length in whole bytes of lines. Bits 31:16 give the clock divider. While enabled, frames follow each other with no gap. The captured input word reaches the parallel input port only once a frame has finished. A read-back version of the control word is also provided, in which the divider field appears shifted left by one bit.

Top module: `sgpio_shift_master`

## Requirements
- R1: After reset, and whenever control bit 0 is 0, the serial clock and the load strobe are both high, no frame runs, and after reset the parallel input word is zero.
- R2: With divider D = control bits 31:16, each serial clock period lasts 2*(D+1) clock cycles. The low half comes first, then the high half.
- R3: A divider value of 0 is treated as 1, giving a 4-cycle serial clock period.
- R4: A frame carries 8*B bits, where B = control bits 9:6. A value of 0 gives 1 byte, and any value above 10 gives 10 bytes (80 lines).
- R5: While enabled, frames run back to back. The load strobe falls together with the serial clock at the start of each frame and stays low for exactly the first serial clock period.
- R6: During serial clock period i of a frame, the serial output carries parallel output bit i, so bit 0 goes first. The serial output changes only when the serial clock falls.
- R7: The serial input is sampled at the rising serial clock of period i into input bit i. The parallel input word changes only on the falling serial clock that ends a frame. It then takes the whole frame's captured bits, with bits at positions 8*B and above set to zero.
- R8: Clearing control bit 0 in the middle of a frame abandons that frame. The clock and load go high on the next cycle, and the parallel input word keeps its previous value.
- R9: The read-back word equals the control word, except that bits 31:16 hold the divider shifted left by one bit (bit 16 is zero and divider bit 15 is dropped).
- R10: The divider and byte count are captured at the start of each frame. A change made during a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Control word: enable bit 0, byte count bits 9:6, divider bits 31:16 |
| ctrl_rd_o | output | 32 | Read-back form of the control word |
| out_data_i | input | 80 | Parallel output values, bit i sent in period i |
| in_data_o | output | 80 | Parallel input values from the last complete frame |
| sclk_o | output | 1 | Serial clock, idle high |
| sload_o | output | 1 | Load strobe, low during the first period of a frame |
| sdo_o | output | 1 | Serial data to the chain |
| sdi_i | input | 1 | Serial data from the chain |

## Verification
The last falling serial clock of a frame does two jobs on one clock edge. It moves the captured word to the parallel input port, and it starts the next frame, which clears the capture register, drops the load strobe and puts output bit 0 on the line. The bench keeps the block enabled across several frames and gives each frame its own input pattern. It then checks that the parallel input shows the previous frame's pattern in the middle of a frame and the new one right after the boundary, and that every frame still sends the full output word. A second collision comes from reprogramming the byte count during a frame. The bench checks that the running frame keeps its captured length and that the following frame uses the new one.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int CTRL_W    = 32;
  localparam int EN_BIT    = 0;
  localparam int BYTES_LSB = 6;
  localparam int BYTES_W   = 4;
  localparam int DIV_LSB   = 16;
  localparam int DIV_W     = 16;
  localparam int HALF_W    = DIV_W + 1;
endpackage

// File: rtl/sgpio_cfg.sv
module sgpio_cfg
  import sgpio_pkg::*;
#(
  parameter int MAX_BYTES = 10,
  localparam int LINES = MAX_BYTES * 8,
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              en_o,
  output logic [HALF_W-1:0] half_o,
  output logic [CNT_W-1:0]  bits_o,
  output logic [CTRL_W-1:0] rd_o
);
  logic [DIV_W-1:0]   div_raw, div_eff;
  logic [BYTES_W-1:0] byt_raw, byt_eff;

  always_comb begin
    div_raw = ctrl_i[DIV_LSB +: DIV_W];
    div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
    half_o  = HALF_W'(div_eff) + HALF_W'(1);
    byt_raw = ctrl_i[BYTES_LSB +: BYTES_W];
    if (byt_raw == '0)                       byt_eff = BYTES_W'(1);
    else if (byt_raw > BYTES_W'(MAX_BYTES))  byt_eff = BYTES_W'(MAX_BYTES);
    else                                     byt_eff = byt_raw;
    bits_o  = CNT_W'(byt_eff) << 3;
    en_o    = ctrl_i[EN_BIT];
    rd_o    = ctrl_i;
    rd_o[DIV_LSB +: DIV_W] = {div_raw[DIV_W-2:0], 1'b0};
  end
endmodule

// File: rtl/sgpio_seq.sv
module sgpio_seq
  import sgpio_pkg::*;
#(
  parameter int LINES = 80,
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [CNT_W-1:0]  bits_i,
  output logic              sclk_o,
  output logic              sload_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              start_o,
  output logic              adv_o,
  output logic              rise_o,
  output logic              done_o
);
  logic              run_q, sclk_q, sload_q;
  logic [HALF_W-1:0] hcnt_q, half_q;
  logic [CNT_W-1:0]  idx_q, bits_q;
  logic              tick, last, fall;

  always_comb begin
    tick    = run_q && (hcnt_q == half_q - HALF_W'(1));
    fall    = tick && sclk_q;
    last    = (idx_q == bits_q - CNT_W'(1));
    rise_o  = en_i && tick && !sclk_q;
    done_o  = en_i && fall && last;
    adv_o   = en_i && fall && !last;
    start_o = en_i && (!run_q || done_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      sclk_q  <= 1'b1;
      sload_q <= 1'b1;
      hcnt_q  <= '0;
      idx_q   <= '0;
      half_q  <= HALF_W'(2);
      bits_q  <= CNT_W'(8);
    end else if (!en_i) begin
      run_q   <= 1'b0;
      sclk_q  <= 1'b1;
      sload_q <= 1'b1;
      hcnt_q  <= '0;
      idx_q   <= '0;
    end else if (start_o) begin
      run_q   <= 1'b1;
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      hcnt_q  <= '0;
      idx_q   <= '0;
      half_q  <= half_i;
      bits_q  <= bits_i;
    end else if (adv_o) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b1;
      hcnt_q  <= '0;
      idx_q   <= idx_q + CNT_W'(1);
    end else if (rise_o) begin
      sclk_q  <= 1'b1;
      hcnt_q  <= '0;
    end else if (run_q) begin
      hcnt_q  <= hcnt_q + HALF_W'(1);
    end
  end

  assign sclk_o  = sclk_q;
  assign sload_o = sload_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/sgpio_shift.sv
module sgpio_shift #(
  parameter int LINES = 80,
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] out_data_i,
  input  logic             sdi_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             start_i,
  input  logic             adv_i,
  input  logic             rise_i,
  input  logic             done_i,
  output logic             sdo_o,
  output logic [LINES-1:0] in_data_o
);
  logic [LINES-1:0] cap_q, cap_d, in_q;
  logic [CNT_W-1:0] nxt;
  logic             sdo_q, nxt_bit;

  for (genvar g = 0; g < LINES; g++) begin : g_cap
    assign cap_d[g] = (rise_i && idx_i == CNT_W'(g)) ? sdi_i : cap_q[g];
  end

  always_comb begin
    nxt     = start_i ? '0 : idx_i + CNT_W'(1);
    nxt_bit = (nxt < CNT_W'(LINES)) ? out_data_i[nxt] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      in_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (done_i)           in_q  <= cap_q;
      if (start_i)          cap_q <= '0;
      else                  cap_q <= cap_d;
      if (start_i || adv_i) sdo_q <= nxt_bit;
    end
  end

  assign sdo_o     = sdo_q;
  assign in_data_o = in_q;
endmodule

// File: rtl/sgpio_shift_master.sv
module sgpio_shift_master
  import sgpio_pkg::*;
#(
  parameter int MAX_BYTES = 10,
  localparam int LINES = MAX_BYTES * 8,
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      ctrl_i,
  output logic [31:0]      ctrl_rd_o,
  input  logic [LINES-1:0] out_data_i,
  output logic [LINES-1:0] in_data_o,
  output logic             sclk_o,
  output logic             sload_o,
  output logic             sdo_o,
  input  logic             sdi_i
);
  logic              en;
  logic [HALF_W-1:0] half;
  logic [CNT_W-1:0]  bits, idx;
  logic              start, adv, rise, done;

  sgpio_cfg #(.MAX_BYTES(MAX_BYTES)) u_cfg (
    .ctrl_i (ctrl_i),
    .en_o   (en),
    .half_o (half),
    .bits_o (bits),
    .rd_o   (ctrl_rd_o)
  );

  sgpio_seq #(.LINES(LINES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .half_i  (half),
    .bits_i  (bits),
    .sclk_o  (sclk_o),
    .sload_o (sload_o),
    .idx_o   (idx),
    .start_o (start),
    .adv_o   (adv),
    .rise_o  (rise),
    .done_o  (done)
  );

  sgpio_shift #(.LINES(LINES)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .out_data_i (out_data_i),
    .sdi_i      (sdi_i),
    .idx_i      (idx),
    .start_i    (start),
    .adv_i      (adv),
    .rise_i     (rise),
    .done_i     (done),
    .sdo_o      (sdo_o),
    .in_data_o  (in_data_o)
  );
endmodule

// File: rtl/sgpio_shift_master_chk.sv
module sgpio_shift_master_chk #(
  parameter int LINES = 80
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             sclk_o,
  input logic             sload_o,
  input logic             sdo_o,
  input logic [LINES-1:0] in_data_o
);
  // R1
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o && sload_o));

  // R5
  load_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sload_o) |-> $fell(sclk_o));

  // R5
  load_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sload_o) |-> ($fell(sclk_o) || !$past(en_i)));

  // R6
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $fell(sclk_o));

  // R7
  in_on_frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(in_data_o) |-> ($fell(sclk_o) && !sload_o));
endmodule

bind sgpio_shift_master sgpio_shift_master_chk #(.LINES(LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (ctrl_i[0]),
  .sclk_o    (sclk_o),
  .sload_o   (sload_o),
  .sdo_o     (sdo_o),
  .in_data_o (in_data_o)
);

// File: tb/sim_sgpio_shift_master.sv
`timescale 1ns/1ps
module sim_sgpio_shift_master;
  localparam int LINES = 80;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic             rst_ni;
  logic [31:0]      ctrl_i, ctrl_rd_o;
  logic [LINES-1:0] out_data_i, in_data_o;
  logic             sclk_o, sload_o, sdo_o, sdi_i;

  sgpio_shift_master u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .ctrl_rd_o(ctrl_rd_o),
    .out_data_i(out_data_i), .in_data_o(in_data_o),
    .sclk_o(sclk_o), .sload_o(sload_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  // external chain model and frame monitor
  int cyc = 0, frames = 0, k = 0, last_bits = 0, last_fall = 0, last_period = 0;
  int low_cnt = 0, last_low = 0;
  bit prev_sclk = 1, active = 0;
  logic [LINES-1:0] rx_cur = '0, rx_last = '0, pat_cur = '0, pat_next = '0;

  initial sdi_i = 1'b0;

  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni || !ctrl_i[0]) begin
      active = 0;
      prev_sclk = sclk_o;
      low_cnt = 0;
    end else begin
      if (prev_sclk && !sclk_o) begin
        last_period = cyc - last_fall;
        last_fall = cyc;
        if (!sload_o) begin
          if (active) begin
            last_bits = k + 1;
            rx_last = rx_cur;
          end
          active = 1;
          frames++;
          k = 0;
          rx_cur = '0;
          pat_cur = pat_next;
        end else begin
          k++;
        end
        sdi_i = (k < LINES) ? pat_cur[k] : 1'b0;
      end
      if (!prev_sclk && sclk_o && k < LINES) rx_cur[k] = sdo_o;
      if (!sload_o) low_cnt++;
      else if (low_cnt != 0) begin
        last_low = low_cnt;
        low_cnt = 0;
      end
      prev_sclk = sclk_o;
    end
  end

  task automatic chk(input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [15:0] dv, input logic [3:0] by, input logic en);
    return {dv, 6'd0, by, 5'd0, en};
  endfunction

  task automatic wait_frames(input int n);
    int f0 = frames;
    while (frames < f0 + n) @(negedge clk_i);
  endtask

  task automatic stop_run();
    @(negedge clk_i);
    ctrl_i = mk(16'd1, 4'd1, 1'b0);
    repeat (4) @(negedge clk_i);
  endtask

  function automatic logic [LINES-1:0] low_mask(input int nb);
    logic [LINES-1:0] m = '0;
    for (int i = 0; i < nb; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    chk("R1 reset sclk", LINES'(sclk_o), LINES'(1));
    chk("R1 reset sload", LINES'(sload_o), LINES'(1));
    chk("R1 reset in_data", in_data_o, '0);
  endtask

  task automatic t_idle();
    ctrl_i = mk(16'd1, 4'd2, 1'b0);
    repeat (40) @(negedge clk_i);
    chk("R1 no frames while off", LINES'(frames), '0);
    chk("R1 idle sclk", LINES'(sclk_o), LINES'(1));
    chk("R1 idle sload", LINES'(sload_o), LINES'(1));
  endtask

  task automatic t_readback();
    ctrl_i = mk(16'h8005, 4'd3, 1'b0);
    #1 chk("R9 readback drop msb", LINES'(ctrl_rd_o), LINES'({16'h000A, ctrl_i[15:0]}));
    ctrl_i = mk(16'h0007, 4'd11, 1'b0);
    #1 chk("R9 readback shift", LINES'(ctrl_rd_o), LINES'({16'h000E, ctrl_i[15:0]}));
    @(negedge clk_i);
  endtask

  task automatic t_period(input logic [15:0] dv, input int exp, input string req);
    ctrl_i = mk(dv, 4'd1, 1'b1);
    wait_frames(2);
    repeat (3 * exp) @(negedge clk_i);
    chk(req, LINES'(last_period), LINES'(exp));
    chk("R5 load low one period", LINES'(last_low), LINES'(exp));
    stop_run();
  endtask

  task automatic t_bytes(input logic [3:0] by, input int exp);
    ctrl_i = mk(16'd1, by, 1'b1);
    wait_frames(3);
    chk("R4 frame length", LINES'(last_bits), LINES'(exp));
    stop_run();
  endtask

  task automatic t_tx(input logic [3:0] by, input int nb, input logic [LINES-1:0] val);
    out_data_i = val;
    ctrl_i = mk(16'd1, by, 1'b1);
    wait_frames(3);
    chk("R6 serial out lsb first", rx_last, val & low_mask(nb));
    stop_run();
  endtask

  task automatic t_rx_and_cfg();
    logic [LINES-1:0] p1 = 80'hA5C3_0F1E_2D3C_4B5A_6978;
    logic [LINES-1:0] p2 = 80'h1234_5678_9ABC_DEF0_1357;
    logic [LINES-1:0] p3 = 80'hFFFF_0000_FFFF_0000_00C6;
    pat_next = p1;
    ctrl_i = mk(16'd1, 4'd10, 1'b1);
    wait_frames(3);
    chk("R7 input word", in_data_o, p1);
    pat_next = p2;
    wait_frames(1);
    repeat (60) @(negedge clk_i);
    chk("R7 held mid frame", in_data_o, p1);
    wait_frames(1);
    chk("R7 updated at frame end", in_data_o, p2);
    // R10: shrink mid frame
    pat_next = p3;
    ctrl_i = mk(16'd1, 4'd1, 1'b1);
    wait_frames(1);
    chk("R10 running frame keeps length", LINES'(last_bits), LINES'(80));
    wait_frames(1);
    chk("R10 next frame new length", LINES'(last_bits), LINES'(8));
    chk("R7 upper bits zero", in_data_o, p3 & low_mask(8));
    stop_run();
  endtask

  task automatic t_abort();
    logic [LINES-1:0] p4 = 80'h0F0F_F0F0_0F0F_F0F0_0F0F;
    logic [LINES-1:0] snap;
    int f0;
    pat_next = 80'h5555_AAAA_5555_AAAA_5555;
    ctrl_i = mk(16'd1, 4'd10, 1'b1);
    wait_frames(2);
    pat_next = p4;
    wait_frames(1);
    snap = in_data_o;
    chk("R8 pre-abort word", snap, 80'h5555_AAAA_5555_AAAA_5555);
    repeat (100) @(negedge clk_i);
    ctrl_i = mk(16'd1, 4'd10, 1'b0);
    f0 = frames;
    @(negedge clk_i);
    chk("R8 sclk idle next cycle", LINES'(sclk_o), LINES'(1));
    chk("R8 sload idle next cycle", LINES'(sload_o), LINES'(1));
    repeat (400) @(negedge clk_i);
    chk("R8 input word kept", in_data_o, snap);
    chk("R8 no frames after abort", LINES'(frames - f0), '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    ctrl_i = '0;
    out_data_i = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_idle();
    t_readback();
    t_period(16'd1, 4, "R2 period div1");
    t_period(16'd3, 8, "R2 period div3");
    t_period(16'd0, 4, "R3 zero divider");
    t_bytes(4'd2, 16);
    t_bytes(4'd0, 8);
    t_bytes(4'd15, 80);
    t_bytes(4'd10, 80);
    t_tx(4'd10, 80, 80'hDEAD_BEEF_0123_4567_89AB);
    t_tx(4'd2, 16, 80'hFFFF_FFFF_FFFF_FFFF_B4E1);
    t_rx_and_cfg();
    t_abort();
    done_flag = 1;
    summary();
    $finish;
  end
endmodule